// File: doc/BRIEF.md
# Masked Sticky Interrupt Controller

This block gathers event and status conditions from the surrounding audio logic into sticky status bits, and drives a single interrupt request to the host. The conditions come from the transmitter, the rate converter, the clock-recovery lock detector and the receiver error checks. Pulse-like sources are caught on their rising edge. The lock indication is a level, so it is caught on any change of state. A bit that has been caught stays set until the host reads the register that holds it.

The host sees four byte-wide registers through a plain strobed port. Address 0 is the main status register and address 1 is the receiver error status register; both clear on read. Address 2 is the main mask and address 3 is the receiver error mask; both are read/write. Bit 0 of the main status register is not stored. It is a live summary that is high whenever an enabled receiver error is held in the receiver error register.

The interrupt is a registered, active-high OR of the enabled main status bits. The same request can be routed to a shared output pin in place of a zero-data flag.

Top module: `sticky_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all status bits, both masks, `irq_o` and `rdata_o` are 0.
- R2: A 0-to-1 transition on `ev_i[k]` sets main status bit k+2. A level held high after the host has read and cleared that bit does not set it again.
- R3: Main status bit 1 is set when `lock_i` changes in either direction. It is not set again while `lock_i` stays constant.
- R4: A status bit stays set until the host reads its own register. A read of any other address leaves it set.
- R5: When `rd_en_i` is high, the next clock loads `rdata_o` with the addressed register as it was before that edge, and clears an addressed status register. An event that arrives in the same cycle as the clearing read stays set. `rdata_o` holds its value between reads.
- R6: A 0-to-1 transition on `rx_err_i[k]` sets bit k of the receiver error register (address 1). Main status bit 0 equals the OR of the receiver error bits ANDed with the receiver error mask. A read of address 0 does not clear bit 0; a read of address 1 does.
- R7: A mask bit of 1 enables its status bit and 0 blocks it. `irq_o` is, one clock later, the OR of the main status bits ANDed with the main mask.
- R8: Writes (`wr_en_i`) to addresses 2 and 3 load the masks, which read back unchanged. Writes to addresses 0 and 1 have no effect.
- R9: `flag_pin_o` carries `irq_o` when `pin_sel_i` is 1 and `zero_flag_i` when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_i | input | 6 | Event sources, caught on their rising edge |
| lock_i | input | 1 | Clock-recovery lock level, caught on any change |
| rx_err_i | input | 8 | Receiver error conditions, caught on their rising edge |
| zero_flag_i | input | 1 | Zero-data flag that shares the output pin |
| pin_sel_i | input | 1 | 1 routes the interrupt to the shared pin, 0 routes the zero flag |
| addr_i | input | 2 | Register address: 0 main status, 1 rx error status, 2 main mask, 3 rx error mask |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, registered |
| irq_o | output | 1 | Interrupt request, active high, registered |
| flag_pin_o | output | 1 | Shared interrupt / zero-flag pin |

## Verification
Four properties are checked on every cycle. Every newly set event bit traces back to a rising edge of its input. Every newly set lock bit traces back to a change of level. The interrupt follows the enabled status of the previous cycle. A read of a mask returns the mask as it stood before the read.

Some behaviour is visible only through the bench's scenarios, because it spans a read and the cycles around it. These are: clear-on-read with a colliding event, the live summary bit surviving a main read, ignored writes to status addresses, and no retrigger from a held level. The bench checks these against its own model, under seeded random traffic and directed cases.

// File: rtl/sirq_pkg.sv
// Shared constants for the sticky interrupt controller: register
// addresses and bit positions inside the main status register.
package sirq_pkg;
    localparam int ADDR_W = 2;
    typedef enum logic [ADDR_W-1:0] {
        A_MAIN_ST = 2'd0,
        A_RX_ST   = 2'd1,
        A_MAIN_MK = 2'd2,
        A_RX_MK   = 2'd3
    } sirq_addr_e;
    localparam int SUM_BIT  = 0;   // live receiver-error summary
    localparam int LOCK_BIT = 1;   // lock change
    localparam int EV_LSB   = 2;   // first edge-caught event
endpackage

// File: rtl/sirq_edge_det.sv
// Per-bit event detector. It keeps the previous input level and flags
// either a rising edge or any change, chosen by ANY_CHANGE.
// Assumes inputs are already synchronous to clk. The previous level
// resets to 0.
module sirq_edge_det #(
    parameter int W          = 1,
    parameter bit ANY_CHANGE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] prev_o,
    output logic [W-1:0] hit_o
);
    logic [W-1:0] prev_q;

    // Remember the level seen on the last clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (ANY_CHANGE) begin : g_chg
                // Flag a change of level in either direction.
                always_comb hit_o[i] = lvl_i[i] ^ prev_q[i];
            end else begin : g_rise
                // Flag a 0-to-1 transition only.
                always_comb hit_o[i] = lvl_i[i] & ~prev_q[i];
            end
        end
    endgenerate

    assign prev_o = prev_q;
endmodule

// File: rtl/sirq_sticky.sv
// Bank of sticky status bits. A set request wins over a clear in the
// same cycle, so no event is lost to a colliding read.
module sirq_sticky #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] st_o
);
    logic [W-1:0] st_q;

    // Hold bits until cleared; new sets always land.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (clr_i ? '0 : st_q) | set_i;
    end

    assign st_o = st_q;
endmodule

// File: rtl/sticky_irq_ctrl.sv
// Masked sticky interrupt controller. Catches source events into
// clear-on-read status registers, gates them with masks (1 = enabled)
// and drives a registered active-high interrupt. The interrupt can be
// routed to a pin shared with a zero-data flag.
// Assumes all inputs are synchronous to clk and strobes last one cycle.
module sticky_irq_ctrl #(
    parameter int DW = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DW-3:0]              ev_i,
    input  logic                       lock_i,
    input  logic [DW-1:0]              rx_err_i,
    input  logic                       zero_flag_i,
    input  logic                       pin_sel_i,
    input  logic [sirq_pkg::ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]              wdata_i,
    input  logic                       wr_en_i,
    input  logic                       rd_en_i,
    output logic [DW-1:0]              rdata_o,
    output logic                       irq_o,
    output logic                       flag_pin_o
);
    import sirq_pkg::*;
    localparam int NEV = DW - EV_LSB;

    logic [NEV-1:0] ev_prev, ev_hit;
    logic           lock_prev, lock_hit;
    logic [DW-1:0]  rx_prev, rx_hit;
    logic [DW-1:1]  main_st;
    logic [DW-1:0]  rx_st, main_mk, rx_mk, main_view, rdata_q;
    logic           clr_main, clr_rx, irq_q;

    sirq_edge_det #(.W(NEV), .ANY_CHANGE(1'b0)) u_ev_det (
        .clk(clk), .rst_n(rst_n), .lvl_i(ev_i), .prev_o(ev_prev), .hit_o(ev_hit));
    sirq_edge_det #(.W(1), .ANY_CHANGE(1'b1)) u_lock_det (
        .clk(clk), .rst_n(rst_n), .lvl_i(lock_i), .prev_o(lock_prev), .hit_o(lock_hit));
    sirq_edge_det #(.W(DW), .ANY_CHANGE(1'b0)) u_rx_det (
        .clk(clk), .rst_n(rst_n), .lvl_i(rx_err_i), .prev_o(rx_prev), .hit_o(rx_hit));

    // Decode which status register a read clears.
    always_comb begin
        clr_main = rd_en_i && (addr_i == A_MAIN_ST);
        clr_rx   = rd_en_i && (addr_i == A_RX_ST);
    end

    sirq_sticky #(.W(DW-1)) u_main_st (
        .clk(clk), .rst_n(rst_n), .set_i({ev_hit, lock_hit}),
        .clr_i(clr_main), .st_o(main_st));
    sirq_sticky #(.W(DW)) u_rx_st (
        .clk(clk), .rst_n(rst_n), .set_i(rx_hit),
        .clr_i(clr_rx), .st_o(rx_st));

    // Main status as seen by host and interrupt, with live summary bit.
    always_comb main_view = {main_st, |(rx_st & rx_mk)};

    // Mask registers: host writes to mask addresses only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_mk <= '0;
            rx_mk   <= '0;
        end else if (wr_en_i) begin
            if (addr_i == A_MAIN_MK) main_mk <= wdata_i;
            if (addr_i == A_RX_MK)   rx_mk   <= wdata_i;
        end
    end

    // Capture the addressed register on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (rd_en_i) begin
            unique case (addr_i)
                A_MAIN_ST: rdata_q <= main_view;
                A_RX_ST:   rdata_q <= rx_st;
                A_MAIN_MK: rdata_q <= main_mk;
                default:   rdata_q <= rx_mk;
            endcase
        end
    end

    // Registered interrupt from enabled main status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(main_view & main_mk);
    end

    assign rdata_o    = rdata_q;
    assign irq_o      = irq_q;
    assign flag_pin_o = pin_sel_i ? irq_q : zero_flag_i;
endmodule

// File: rtl/sticky_irq_ctrl_chk.sv
// Checker for sticky_irq_ctrl, bound into every instance of the top.
// Relates source inputs, detector history, status and outputs across
// clock edges.
module sticky_irq_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-3:0] ev_i,
    input logic [DW-3:0] ev_prev,
    input logic          lock_i,
    input logic          lock_prev,
    input logic [DW-1:1] main_st,
    input logic [DW-1:0] main_view,
    input logic [DW-1:0] main_mk,
    input logic [1:0]    addr_i,
    input logic          rd_en_i,
    input logic [DW-1:0] rdata_o,
    input logic          irq_o
);
    // New event bits must come from a rising edge of their source.
    assert_ev_from_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((main_st[DW-1:2] & ~$past(main_st[DW-1:2])) & ~$past(ev_i & ~ev_prev)) == '0);

    // The lock bit rises only after the lock level changed.
    assert_lock_on_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_st[1]) |-> ($past(lock_i) != $past(lock_prev)));

    // Interrupt follows the enabled status of the previous cycle.
    assert_irq_follows_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(main_view & main_mk)));

    // Reading the main mask returns its earlier contents.
    assert_mask_readback_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en_i) && $past(addr_i) == 2'd2) |-> rdata_o == $past(main_mk));
endmodule

bind sticky_irq_ctrl sticky_irq_ctrl_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .ev_prev(ev_prev),
    .lock_i(lock_i), .lock_prev(lock_prev), .main_st(main_st),
    .main_view(main_view), .main_mk(main_mk), .addr_i(addr_i),
    .rd_en_i(rd_en_i), .rdata_o(rdata_o), .irq_o(irq_o));

// File: tb/tb_sticky_irq_ctrl.sv
module tb_sticky_irq_ctrl;
    localparam int DW = 8;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [DW-3:0] ev_i = '0;
    logic lock_i = 1'b0, zero_flag_i = 1'b0, pin_sel_i = 1'b0;
    logic [DW-1:0] rx_err_i = '0, wdata_i = '0;
    logic [1:0] addr_i = '0;
    logic wr_en_i = 1'b0, rd_en_i = 1'b0;
    logic [DW-1:0] rdata_o;
    logic irq_o, flag_pin_o;
    int n_chk = 0, n_fail = 0;

    // Bench-side model state
    logic [DW-1:1] m_main;
    logic [DW-1:0] m_rx, m_mmk, m_rmk, m_rdata;
    logic [DW-3:0] p_ev;
    logic [DW-1:0] p_rx;
    logic p_lock, m_irq;

    always #5 clk = ~clk;

    sticky_irq_ctrl #(.DW(DW)) dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] view_of(input logic [DW-1:1] mn,
                                               input logic [DW-1:0] rx, input logic [DW-1:0] rmk);
        return {mn, |(rx & rmk)};
    endfunction

    task automatic model_reset();
        m_main = '0; m_rx = '0; m_mmk = '0; m_rmk = '0; m_rdata = '0;
        p_ev = '0; p_rx = '0; p_lock = 1'b0; m_irq = 1'b0;
    endtask

    // One clock: update the model at the edge, check outputs at negedge.
    task automatic step();
        logic [DW-1:0] v;
        logic [DW-3:0] evh;
        logic [DW-1:0] rxh;
        logic lkh, nirq;
        @(posedge clk);
        v    = view_of(m_main, m_rx, m_rmk);
        nirq = |(v & m_mmk);
        evh  = ev_i & ~p_ev;
        rxh  = rx_err_i & ~p_rx;
        lkh  = lock_i ^ p_lock;
        if (rd_en_i) begin
            case (addr_i)
                2'd0: m_rdata = v;
                2'd1: m_rdata = m_rx;
                2'd2: m_rdata = m_mmk;
                default: m_rdata = m_rmk;
            endcase
        end
        if (rd_en_i && addr_i == 2'd0) m_main = '0;
        if (rd_en_i && addr_i == 2'd1) m_rx = '0;
        m_main = m_main | {evh, lkh};
        m_rx   = m_rx | rxh;
        if (wr_en_i && addr_i == 2'd2) m_mmk = wdata_i;
        if (wr_en_i && addr_i == 2'd3) m_rmk = wdata_i;
        m_irq = nirq;
        p_ev = ev_i; p_rx = rx_err_i; p_lock = lock_i;
        @(negedge clk);
        check("R7", irq_o, m_irq);
        check("R9", flag_pin_o, pin_sel_i ? m_irq : zero_flag_i);
        check("R5", rdata_o, m_rdata);
        rd_en_i = 1'b0; wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        addr_i = a; rd_en_i = 1'b1; step();
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", irq_o, 0);
        check("R1", rdata_o, 0);
        rd(2'd2); check("R1", rdata_o, 0);
        rd(2'd0); check("R1", rdata_o, 0);

        // R2: rising edge catches, held level does not retrigger
        ev_i[0] = 1'b1; step();
        rd(2'd0); check("R2", rdata_o, 8'h04);
        step();
        rd(2'd0); check("R2", rdata_o, 8'h00);
        ev_i[0] = 1'b0; step();

        // R3: lock change both ways
        lock_i = 1'b1; step();
        rd(2'd0); check("R3", rdata_o, 8'h02);
        step(); rd(2'd0); check("R3", rdata_o, 8'h00);
        lock_i = 1'b0; step();
        rd(2'd0); check("R3", rdata_o, 8'h02);

        // R4: other reads do not clear
        ev_i[3] = 1'b1; step(); ev_i[3] = 1'b0;
        rd(2'd1); rd(2'd2); rd(2'd3);
        rd(2'd0); check("R4", rdata_o, 8'h20);

        // R5: event in same cycle as clearing read survives
        ev_i[1] = 1'b1; step(); ev_i[1] = 1'b0;
        ev_i[2] = 1'b1; rd(2'd0); check("R5", rdata_o, 8'h08);
        ev_i[2] = 1'b0;
        rd(2'd0); check("R5", rdata_o, 8'h10);

        // R6: receiver errors and the live summary bit
        rx_err_i[5] = 1'b1; step(); rx_err_i[5] = 1'b0;
        rd(2'd0); check("R6", rdata_o, 8'h00);
        wr(2'd3, 8'h20);
        rd(2'd0); check("R6", rdata_o, 8'h01);
        rd(2'd0); check("R6", rdata_o, 8'h01);
        rd(2'd1); check("R6", rdata_o, 8'h20);
        rd(2'd0); check("R6", rdata_o, 8'h00);

        // R7: mask enables interrupt, irq one cycle after status
        wr(2'd2, 8'h10);
        ev_i[2] = 1'b1; step(); ev_i[2] = 1'b0;
        check("R7", irq_o, 0);
        step(); check("R7", irq_o, 1);
        wr(2'd2, 8'h00); step(); check("R7", irq_o, 0);
        rd(2'd0);

        // R8: status addresses ignore writes, masks read back
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        rd(2'd0); check("R8", rdata_o, 8'h00);
        rd(2'd1); check("R8", rdata_o, 8'h00);
        wr(2'd3, 8'h5A); rd(2'd3); check("R8", rdata_o, 8'h5A);

        // R9: shared pin both ways
        pin_sel_i = 1'b0; zero_flag_i = 1'b1; step(); check("R9", flag_pin_o, 1);
        pin_sel_i = 1'b1; step(); check("R9", flag_pin_o, irq_o);

        // Random traffic against the model
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3000; i++) begin
            ev_i        = ev_i ^ ($urandom % 4 == 0 ? DW'($urandom) : '0);
            rx_err_i    = rx_err_i ^ ($urandom % 4 == 0 ? DW'($urandom) : '0);
            lock_i      = ($urandom % 8 == 0) ? ~lock_i : lock_i;
            zero_flag_i = 1'($urandom);
            pin_sel_i   = 1'($urandom);
            addr_i      = 2'($urandom);
            wdata_i     = DW'($urandom);
            rd_en_i     = ($urandom % 3 == 0);
            wr_en_i     = ($urandom % 5 == 0);
            step();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule